// File: doc/BRIEF.md
# Partitioned LRU Line Buffer Allocator

This block chooses which of four flash line buffers receives a newly fetched line, and it keeps the recency order of those buffers. A tag-compare stage outside the block looks up a request and hands over the result as a one-hot hit vector. The request also carries a flag for instruction versus data and a flag for a sequential prefetch. On a hit, the block moves the matching buffer to most-recently-used. On a miss, it names a victim, which is the least recently used buffer in the group that serves the request's access type.

A four-bit configuration register sets the grouping. All four buffers can form one shared pool, or they can be split between instruction fetches and data accesses in a 2/2 or a 3/1 ratio. A parameter gives the register's reset value, so two instances can start with different layouts. A sequential prefetch still gets a victim, but the victim is not promoted. That buffer reaches most-recently-used only when a later request hits it.

Top module: `lruAlloc`

## Requirements
- R1: After reset, the recency order is buffer 0 in slot 0 (most recent), then buffers 1, 2 and 3 in slots 1, 2 and 3, so `orderOut` reads 8'hE4. The configuration register holds `CFG_RESET`.
- R2: A request with a hit in buffer b puts b in slot 0 on the next clock edge. Buffers that stood ahead of b each move down one slot, and buffers that stood behind b keep their slots. `orderOut[2k+1:2k]` is the buffer index in slot k.
- R3: When the configuration bits [1:0] are 00 or 01, every buffer belongs to both access types. The victim is then the buffer in slot 3.
- R4: When the configuration bits [1:0] are 10, buffers 0 and 1 serve instruction requests (`reqIsInstr`=1) and buffers 2 and 3 serve data requests. The victim is the group member nearest slot 3.
- R5: When the configuration bits [1:0] are 11, buffers 0, 1 and 2 serve instruction requests and buffer 3 alone serves data requests. The victim is the group member nearest slot 3.
- R6: A miss with `reqSeq`=0 promotes the victim to slot 0 on the next edge, and the other buffers shift as in R2.
- R7: A miss with `reqSeq`=1 leaves the recency order unchanged. A later hit in that buffer promotes it as in R2.
- R8: Configuration bits [3:2] have no effect on grouping or victim choice.
- R9: Asserting `cfgWe` loads `cfgIn` on the clock edge. The new grouping applies from the next cycle on, and the recency order is kept.
- R10: `victimValid` is high in the same cycle exactly when `reqValid` is high and `hitVec` is zero. `victimIdx` is valid whenever `victimValid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Load strobe for the configuration register |
| cfgIn | input | 4 | New configuration value |
| reqValid | input | 1 | Lookup request present |
| reqIsInstr | input | 1 | 1 = instruction fetch, 0 = data access |
| reqSeq | input | 1 | Request is a sequential-line prefetch |
| hitVec | input | 4 | One-hot tag-match result, zero on a miss |
| victimValid | output | 1 | Miss this cycle, victim index valid |
| victimIdx | output | 2 | Buffer chosen for allocation |
| orderOut | output | 8 | Recency order, slot 0 most recent in bits [1:0] |

## Verification
The assertions assume that `hitVec` is one-hot or zero, as a tag compare over distinct lines produces. A dedicated check flags any input that breaks this. The random stimulus therefore drives either no hit or exactly one randomly chosen buffer. It mixes instruction and data requests, sequential and plain misses, and configuration writes that cover all sixteen codes, so the reserved and upper-bit cases are exercised too. Directed sequences cover the reset grouping, a sequential miss followed by a hit, and a configuration change while the order is non-trivial.

// File: rtl/lru_pkg.sv
package lru_pkg;
  localparam int NUM_BUF = 4;
  localparam int IDX_W = $clog2(NUM_BUF);
  localparam int CFG_W = 4;

  typedef logic [IDX_W-1:0] bufIdx_t;

  // strobe bundle from control to the order datapath
  typedef struct packed {
    logic    promote;
    bufIdx_t idx;
  } orderCmd_t;

  // group membership per access type; reserved 01 falls back to the pool
  function automatic logic [NUM_BUF-1:0] groupMask(input logic [1:0] mode,
                                                   input logic isInstr);
    case (mode)
      2'b10:   return isInstr ? 4'b0011 : 4'b1100;
      2'b11:   return isInstr ? 4'b0111 : 4'b1000;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/lruCtrl.sv
module lruCtrl
  import lru_pkg::*;
#(
  parameter logic [CFG_W-1:0] CFG_RESET = '0
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            cfgWe,
  input  logic [CFG_W-1:0]                cfgIn,
  input  logic                            reqValid,
  input  logic                            reqIsInstr,
  input  logic                            reqSeq,
  input  logic [NUM_BUF-1:0]              hitVec,
  input  logic [NUM_BUF-1:0][IDX_W-1:0]   orderIn,
  output orderCmd_t                       cmd,
  output logic                            victimValid,
  output bufIdx_t                         victimIdx
);
  logic [CFG_W-1:0]   cfgQ;
  logic [NUM_BUF-1:0] mask;
  logic               isHit;
  bufIdx_t            hitIdx;

  always_ff @(posedge clk) begin
    if (!rstN)      cfgQ <= CFG_RESET;
    else if (cfgWe) cfgQ <= cfgIn;
  end

  assign mask  = groupMask(cfgQ[1:0], reqIsInstr);
  assign isHit = |hitVec;

  // scan from least recent slot upward for the first group member
  always_comb begin
    logic found;
    found     = 1'b0;
    victimIdx = orderIn[NUM_BUF-1];
    for (int s = NUM_BUF - 1; s >= 0; s--) begin
      if (!found && mask[orderIn[s]]) begin
        victimIdx = orderIn[s];
        found     = 1'b1;
      end
    end
  end

  always_comb begin
    hitIdx = '0;
    for (int b = 0; b < NUM_BUF; b++)
      if (hitVec[b]) hitIdx = bufIdx_t'(b);
  end

  assign victimValid = reqValid && !isHit;
  assign cmd.promote = reqValid && (isHit || !reqSeq);
  assign cmd.idx     = isHit ? hitIdx : victimIdx;

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $onehot0(hitVec)); // R2
  AST_VICTIM_IN_GROUP: assert property (@(posedge clk) disable iff (!rstN)
    victimValid |-> groupMask(cfgQ[1:0], reqIsInstr)[victimIdx]); // R4
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> cfgQ == $past(cfgIn)); // R9
endmodule

// File: rtl/lruOrder.sv
module lruOrder
  import lru_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  orderCmd_t                     cmd,
  output logic [NUM_BUF-1:0][IDX_W-1:0] orderQ
);
  logic [NUM_BUF-1:0][IDX_W-1:0] orderD;
  logic [NUM_BUF-1:0]            present;

  // move cmd.idx to slot 0, shifting the slots ahead of it down by one
  always_comb begin
    logic passed;
    passed = 1'b0;
    orderD = orderQ;
    if (cmd.promote) begin
      orderD[0] = cmd.idx;
      passed = (orderQ[0] == cmd.idx);
      for (int s = 1; s < NUM_BUF; s++) begin
        if (!passed) orderD[s] = orderQ[s-1];
        if (orderQ[s] == cmd.idx) passed = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_BUF; s++) orderQ[s] <= bufIdx_t'(s);
    end else begin
      orderQ <= orderD;
    end
  end

  always_comb begin
    present = '0;
    for (int s = 0; s < NUM_BUF; s++) present[orderQ[s]] = 1'b1;
  end

  AST_ORDER_PERMUTATION: assert property (@(posedge clk) disable iff (!rstN)
    $countones(present) == NUM_BUF); // R2
  AST_PROMOTE_MRU: assert property (@(posedge clk) disable iff (!rstN)
    cmd.promote |=> orderQ[0] == $past(cmd.idx)); // R6
  AST_HOLD_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.promote |=> $stable(orderQ)); // R7
endmodule

// File: rtl/lruAlloc.sv
module lruAlloc
  import lru_pkg::*;
#(
  parameter logic [CFG_W-1:0] CFG_RESET = 4'b0000
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgWe,
  input  logic [CFG_W-1:0]         cfgIn,
  input  logic                     reqValid,
  input  logic                     reqIsInstr,
  input  logic                     reqSeq,
  input  logic [NUM_BUF-1:0]       hitVec,
  output logic                     victimValid,
  output logic [IDX_W-1:0]         victimIdx,
  output logic [NUM_BUF*IDX_W-1:0] orderOut
);
  orderCmd_t                     cmd;
  logic [NUM_BUF-1:0][IDX_W-1:0] order;

  lruCtrl #(.CFG_RESET(CFG_RESET)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIn(cfgIn),
    .reqValid(reqValid), .reqIsInstr(reqIsInstr), .reqSeq(reqSeq),
    .hitVec(hitVec), .orderIn(order), .cmd(cmd),
    .victimValid(victimValid), .victimIdx(victimIdx)
  );

  lruOrder uOrder (
    .clk(clk), .rstN(rstN), .cmd(cmd), .orderQ(order)
  );

  assign orderOut = order;
endmodule

// File: tb/tb_lruAlloc.sv
module tb_lruAlloc;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [3:0] cfgIn = '0;
  logic reqValid = 1'b0, reqIsInstr = 1'b0, reqSeq = 1'b0;
  logic [3:0] hitVec = '0;
  logic victimValid;
  logic [1:0] victimIdx;
  logic [7:0] orderOut;

  int checks = 0, errors = 0;
  logic [1:0] mOrd [4];
  logic [3:0] mCfg;
  string lastTag = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  lruAlloc #(.CFG_RESET(4'b0011)) dut (.*);

  function automatic bit inGroup(input logic [3:0] cfg, input logic instr,
                                 input logic [1:0] b);
    if (cfg[1:0] == 2'b10) return instr ? (b <= 1) : (b >= 2);
    if (cfg[1:0] == 2'b11) return instr ? (b != 3) : (b == 3);
    return 1;
  endfunction

  function automatic logic [1:0] expVictim(input logic [3:0] cfg, input logic instr);
    for (int s = 3; s >= 0; s--) if (inGroup(cfg, instr, mOrd[s])) return mOrd[s];
    return mOrd[3];
  endfunction

  function automatic string modeTag(input logic [3:0] cfg);
    if (cfg[1:0] == 2'b10) return "R4";
    if (cfg[1:0] == 2'b11) return "R5";
    return "R3";
  endfunction

  task automatic promote(input logic [1:0] b);
    int p = 0;
    for (int s = 0; s < 4; s++) if (mOrd[s] == b) p = s;
    for (int s = p; s > 0; s--) mOrd[s] = mOrd[s-1];
    mOrd[0] = b;
  endtask

  function automatic logic [7:0] packOrd();
    return {mOrd[3], mOrd[2], mOrd[1], mOrd[0]};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doReq(input logic we, input logic [3:0] cfg, input logic v,
                       input logic instr, input logic seq, input logic [3:0] hit,
                       input string tag);
    logic expVV;
    logic [1:0] expVI;
    @(negedge clk);
    check(orderOut == packOrd(), lastTag, orderOut, packOrd());
    cfgWe = we; cfgIn = cfg; reqValid = v; reqIsInstr = instr; reqSeq = seq; hitVec = hit;
    #1;
    expVV = v && (hit == 0);
    expVI = expVictim(mCfg, instr);
    check(victimValid == expVV, "R10", victimValid, expVV);
    if (expVV) check(victimIdx == expVI, (tag == "") ? modeTag(mCfg) : tag, victimIdx, expVI);
    @(posedge clk);
    if (v) begin
      if (hit != 0) begin
        for (int b = 0; b < 4; b++) if (hit[b]) promote(2'(b));
      end else if (!seq) promote(expVI);
    end
    if (we) mCfg = cfg;
    lastTag = (hit != 0) ? "R2" : (v && seq) ? "R7" : v ? "R6" : we ? "R9" : "R2";
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) mOrd[s] = 2'(s);
    mCfg = 4'b0011;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(orderOut == 8'hE4, "R1", orderOut, 8'hE4);
    // reset configuration 0011: instruction LRU is buffer 2, data is buffer 3
    doReq(0, 0, 1, 1, 1, 4'b0000, "R1");
    doReq(0, 0, 1, 0, 1, 4'b0000, "R5");
    // sequential miss on data leaves order, then a hit promotes buffer 3
    doReq(0, 0, 1, 0, 1, 4'b0000, "R7");
    doReq(0, 0, 1, 0, 0, 4'b1000, "R7");
    // upper bits set with mode 10
    doReq(1, 4'b1110, 0, 0, 0, 4'b0000, "R9");
    doReq(0, 0, 1, 1, 0, 4'b0000, "R8");
    doReq(0, 0, 1, 0, 0, 4'b0000, "R8");
    // reserved 01 acts as the pool
    doReq(1, 4'b0101, 0, 0, 0, 4'b0000, "R9");
    doReq(0, 0, 1, 1, 0, 4'b0000, "R3");
    doReq(0, 0, 1, 0, 0, 4'b0010, "R2");
    void'($urandom(32'h1234));
    for (int i = 0; i < 4000; i++) begin
      logic we = ($urandom % 16) == 0;
      logic [3:0] hit = ($urandom % 2) ? 4'(1 << ($urandom % 4)) : 4'b0;
      doReq(we, 4'($urandom), ($urandom % 8) != 0, 1'($urandom), 1'($urandom), hit, "");
    end
    @(negedge clk);
    check(orderOut == packOrd(), lastTag, orderOut, packOrd());
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule